// File: doc/BRIEF.md
# FIR Neuron Layer with Shared Activation Bus

This block is one layer of a finite-impulse-response neural network. Each neuron of the layer has its own coefficient ROM and bias, and keeps a short tapped history of the input stream. When a new sample is accepted, the same input word is broadcast to every neuron at once. Each neuron preloads its accumulator with its bias and adds one coefficient-times-history product per cycle. It then clamps the scaled sum into an 8-bit table index and holds that index until it is allowed onto the bus.

All neurons share one 8-bit bus and one 256-entry sigmoid table. A round-robin arbiter hands out the bus one neuron per cycle. The table has a one-cycle read latency, so one activation per cycle comes out of the layer, tagged with the index of the neuron that produced it. The coefficients and biases are fixed when the design is elaborated; nothing changes them at run time.

Top module: `fir_neuron_layer`

## Requirements
- R1: After reset, `sig_valid_o` is 0 and `bus_o` is 0, and every neuron's input history holds zeros.
- R2: For an accepted sample k, neuron n's accumulator holds bias(n) + sum over m=0..TAPS-1 of coef(n,m)*x[k-m], as 18-bit two's complement. Tap m=0 is the newest sample, and samples before reset count as 0.
- R3: coef(n,m) is the 8-bit two's complement reading of (n*COEF_STEP_N + m*COEF_STEP_M + COEF_BASE) mod 256. bias(n) = BIAS_BASE + n*BIAS_STEP.
- R4: The index a neuron places on the bus is the accumulator shifted right arithmetically by SHIFT bits (floor division by 2^SHIFT), clamped to the range -128..127.
- R5: The table is addressed by the index plus 128 and has 256 entries. Let a=|idx|. Then y=128+4a for a<16, y=160+2a for a<38, y=216+a/2 (integer division) for a<80, and y=256 otherwise. For a negative index y becomes 256-y. The output is min(y,255).
- R6: The results of one sample leave in neuron order 0..NEURONS-1, in consecutive cycles, with `sig_idx_o` giving the neuron number.
- R7: Counting from the rising edge that accepts a sample, `bus_o` carries neuron j's index in the cycle after edge TAPS+2+j. `sig_o` and `sig_valid_o` present that neuron's result in the cycle after edge TAPS+3+j.
- R8: `bus_o` is 0 in every cycle in which no neuron holds the bus, and `sig_valid_o` is 0 in the following cycle.
- R9: A `sample_valid_i` pulse while any neuron of the layer is busy is dropped and leaves every neuron's history unchanged.
- R10: At most one neuron holds the bus in any cycle, only a requesting neuron is granted, and the search for the next grant starts from the neuron after the one granted last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_valid_i | input | 1 | A new input sample is offered |
| sample_i | input | 8 | Signed input sample, broadcast to all neurons |
| bus_o | output | 8 | Shared bus: the granted neuron's table index |
| sig_valid_o | output | 1 | `sig_o` holds a new activation |
| sig_idx_o | output | 2 | Number of the neuron that owns `sig_o` |
| sig_o | output | 8 | Sigmoid table output, unsigned fraction of 256 |

## Verification
The hardest case to reach from the ports is a sample offered while the layer is only partly busy. During the bus phase, neuron 0 is already idle while the others still wait for the bus. A careless gate would let that neuron start alone and lose step with the rest of the layer. The bench pulses `sample_valid_i` once during the multiply phase and once during that bus phase. It then shows that the next accepted sample still matches a model whose history never took the dropped words. Runs of full-scale positive and negative samples drive the clamp to both limits, and an impulse walks one nonzero word through every tap so that each coefficient and the bias can be seen on their own.

// File: rtl/fir_nrn_pkg.sv
package fir_nrn_pkg;
  localparam int DATA_W      = 8;
  localparam int ACC_W       = 18;
  localparam int SIG_W       = 8;
  localparam int SIG_ENTRIES = 256;

  typedef enum logic [2:0] {S_IDLE, S_MAC, S_DRAIN, S_BUF, S_WAIT} nrn_state_e;

  function automatic logic signed [DATA_W-1:0] coef_val(int n, int m, int step_n, int step_m,
                                                        int base);
    int v;
    v = (n * step_n + m * step_m + base) % 256;
    return DATA_W'(v);
  endfunction

  // piecewise-linear sigmoid, input in 1/16 units, output in 1/256 units
  function automatic logic [SIG_W-1:0] sigmoid_val(logic signed [DATA_W-1:0] x);
    int a, y;
    a = (x < 0) ? -int'(x) : int'(x);
    if (a < 16)      y = 128 + 4 * a;
    else if (a < 38) y = 160 + 2 * a;
    else if (a < 80) y = 216 + a / 2;
    else             y = 256;
    if (x < 0) y = 256 - y;
    if (y > 255) y = 255;
    return SIG_W'(y);
  endfunction

  function automatic logic signed [DATA_W-1:0] sat_index(logic signed [ACC_W-1:0] acc, int shift);
    logic signed [ACC_W-1:0] s;
    s = acc >>> shift;
    if (s > 18'sd127)  return 8'sd127;
    if (s < -18'sd128) return -8'sd128;
    return s[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/fir_neuron.sv
module fir_neuron
  import fir_nrn_pkg::*;
#(
  parameter int NEURON_ID   = 0,
  parameter int TAPS        = 4,
  parameter int SHIFT       = 6,
  parameter int COEF_STEP_N = 37,
  parameter int COEF_STEP_M = 23,
  parameter int COEF_BASE   = 5,
  parameter int BIAS        = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic                     grant_i,
  output logic                     idle_o,
  output logic                     req_o,
  output logic signed [DATA_W-1:0] idx_o
);
  localparam int TAP_W  = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int PROD_W = 2 * DATA_W;
  localparam logic signed [ACC_W-1:0] BIAS_Q = ACC_W'(BIAS);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(TAPS - 1);

  nrn_state_e                state_q;
  logic        [TAP_W-1:0]   tap_q;
  logic signed [DATA_W-1:0]  dly_q [TAPS];
  logic signed [DATA_W-1:0]  rom   [TAPS];
  logic signed [PROD_W-1:0]  prod_q;
  logic                      pvalid_q;
  logic signed [ACC_W-1:0]   acc_q;
  logic signed [DATA_W-1:0]  out_q;

  always_comb begin
    for (int m = 0; m < TAPS; m++)
      rom[m] = coef_val(NEURON_ID, m, COEF_STEP_N, COEF_STEP_M, COEF_BASE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      tap_q    <= '0;
      prod_q   <= '0;
      pvalid_q <= 1'b0;
      acc_q    <= '0;
      out_q    <= '0;
      for (int m = 0; m < TAPS; m++) dly_q[m] <= '0;
    end else begin
      pvalid_q <= (state_q == S_MAC);
      if (pvalid_q) acc_q <= acc_q + {{(ACC_W-PROD_W){prod_q[PROD_W-1]}}, prod_q};
      unique case (state_q)
        S_IDLE: if (start_i) begin
          for (int m = TAPS - 1; m > 0; m--) dly_q[m] <= dly_q[m-1];
          dly_q[0] <= sample_i;
          acc_q    <= BIAS_Q;
          tap_q    <= '0;
          state_q  <= S_MAC;
        end
        S_MAC: begin
          prod_q <= rom[tap_q] * dly_q[tap_q];
          if (tap_q == LAST_TAP) state_q <= S_DRAIN;
          else                   tap_q   <= tap_q + 1'b1;
        end
        S_DRAIN: state_q <= S_BUF;
        S_BUF: begin
          out_q   <= sat_index(acc_q, SHIFT);
          state_q <= S_WAIT;
        end
        S_WAIT: if (grant_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign idle_o = (state_q == S_IDLE);
  assign req_o  = (state_q == S_WAIT);
  assign idx_o  = out_q;

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !grant_i |=> req_o); // R6
  AST_REQ_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |=> !req_o); // R10
  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> state_q == S_IDLE); // R9
  AST_NO_PRODUCT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_IDLE |-> !pvalid_q); // R2
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] grant_idx_o
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    logic found;
    found       = 1'b0;
    grant_o     = '0;
    grant_idx_o = '0;
    for (int off = 0; off < N; off++) begin
      int j;
      j = (int'(ptr_q) + off) % N;
      if (!found && req_i[j]) begin
        found       = 1'b1;
        grant_o[j]  = 1'b1;
        grant_idx_o = IDX_W'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ptr_q <= '0;
    else if (|grant_o)    ptr_q <= (int'(grant_idx_o) == N - 1) ? '0 : grant_idx_o + 1'b1;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R10
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~req_i) == '0); // R10
  AST_NO_IDLE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |req_i |-> |grant_o); // R10
endmodule

// File: rtl/sigmoid_lut.sv
module sigmoid_lut
  import fir_nrn_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [IDX_W-1:0]         owner_i,
  input  logic signed [DATA_W-1:0] addr_i,
  output logic                     valid_o,
  output logic [IDX_W-1:0]         owner_o,
  output logic [SIG_W-1:0]         data_o
);
  logic [SIG_W-1:0] lut_rom [SIG_ENTRIES];

  always_comb begin
    for (int e = 0; e < SIG_ENTRIES; e++) lut_rom[e] = sigmoid_val(DATA_W'(e - SIG_ENTRIES / 2));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      owner_o <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        owner_o <= owner_i;
        data_o  <= lut_rom[{~addr_i[DATA_W-1], addr_i[DATA_W-2:0]}];  // offset binary
      end
    end
  end

  AST_ONE_CYCLE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R7
  AST_SIG_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && addr_i == -8'sd128 |=> data_o == '0); // R5
endmodule

// File: rtl/fir_neuron_layer.sv
module fir_neuron_layer
  import fir_nrn_pkg::*;
#(
  parameter int NEURONS     = 4,
  parameter int TAPS        = 4,
  parameter int SHIFT       = 6,
  parameter int COEF_STEP_N = 37,
  parameter int COEF_STEP_M = 23,
  parameter int COEF_BASE   = 5,
  parameter int BIAS_BASE   = -300,
  parameter int BIAS_STEP   = 150,
  parameter int IDX_W       = (NEURONS > 1) ? $clog2(NEURONS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [7:0]        sample_i,
  output logic [7:0]        bus_o,
  output logic              sig_valid_o,
  output logic [IDX_W-1:0]  sig_idx_o,
  output logic [7:0]        sig_o
);
  logic [NEURONS-1:0]       idle, req, grant;
  logic [IDX_W-1:0]         grant_idx;
  logic signed [DATA_W-1:0] nrn_idx [NEURONS];
  logic                     start;
  logic [DATA_W-1:0]        bus;

  assign start = sample_valid_i & (&idle);

  for (genvar n = 0; n < NEURONS; n++) begin : g_nrn
    fir_neuron #(
      .NEURON_ID  (n),
      .TAPS       (TAPS),
      .SHIFT      (SHIFT),
      .COEF_STEP_N(COEF_STEP_N),
      .COEF_STEP_M(COEF_STEP_M),
      .COEF_BASE  (COEF_BASE),
      .BIAS       (BIAS_BASE + n * BIAS_STEP)
    ) u_nrn (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .sample_i(sample_i),
      .grant_i (grant[n]),
      .idle_o  (idle[n]),
      .req_o   (req[n]),
      .idx_o   (nrn_idx[n])
    );
  end

  rr_arbiter #(.N(NEURONS), .IDX_W(IDX_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .grant_o    (grant),
    .grant_idx_o(grant_idx)
  );

  always_comb begin
    bus = '0;
    for (int n = 0; n < NEURONS; n++) if (grant[n]) bus = bus | nrn_idx[n];
  end
  assign bus_o = bus;

  sigmoid_lut #(.IDX_W(IDX_W)) u_lut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(|grant),
    .owner_i(grant_idx),
    .addr_i (bus),
    .valid_o(sig_valid_o),
    .owner_o(sig_idx_o),
    .data_o (sig_o)
  );

  AST_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant == '0 |-> bus_o == '0); // R8
  AST_SIG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant == '0 |=> !sig_valid_o); // R8
  AST_LOCKSTEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> idle == '0); // R9
endmodule

// File: tb/fir_neuron_layer_tb_top.sv
`timescale 1ns/1ps
module fir_neuron_layer_tb_top;
  localparam int N = 4, T = 4, SH = 6;

  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0;
  logic [7:0] smp = '0;
  logic [7:0] bus;
  logic       sv;
  logic [1:0] sidx;
  logic [7:0] sig;
  int checks = 0, errors = 0;
  int hist [T];
  int exp_idx [N];
  bit done = 0;

  always #2.5 clk = ~clk;

  fir_neuron_layer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(vld), .sample_i(smp),
    .bus_o(bus), .sig_valid_o(sv), .sig_idx_o(sidx), .sig_o(sig)
  );

  function automatic int coef(int n, int m);  // R3
    int v = (n * 37 + m * 23 + 5) % 256;
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic int sig_ref(int x);  // R5
    int a = (x < 0) ? -x : x, y;
    if (a < 16) y = 128 + 4 * a; else if (a < 38) y = 160 + 2 * a;
    else if (a < 80) y = 216 + a / 2; else y = 256;
    if (x < 0) y = 256 - y;
    return (y > 255) ? 255 : y;
  endfunction

  function automatic int sat_ref(int acc);  // R4
    int s = acc >>> SH;
    return (s > 127) ? 127 : ((s < -128) ? -128 : s);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_sample(int x, bit early_drop, bit late_drop);
    for (int m = T - 1; m > 0; m--) hist[m] = hist[m-1];
    hist[0] = x;
    for (int n = 0; n < N; n++) begin
      int acc = -300 + n * 150;  // R2 R3
      for (int m = 0; m < T; m++) acc += coef(n, m) * hist[m];
      exp_idx[n] = sat_ref(acc);
    end
    @(negedge clk); vld = 1'b1; smp = 8'(x);
    @(posedge clk);                                  // accepting edge
    @(negedge clk); vld = 1'b0;
    if (early_drop) begin                            // R9 pulse while busy
      @(posedge clk); @(negedge clk); vld = 1'b1; smp = 8'(x + 77);
      @(posedge clk); @(negedge clk); vld = 1'b0;
      repeat (T) @(posedge clk);
    end else repeat (T + 2) @(posedge clk);
    for (int j = 0; j <= N; j++) begin
      @(negedge clk);
      if (j < N) check(bus == 8'(exp_idx[j]), "R7 bus index", int'($signed(bus)), exp_idx[j]);
      if (j > 0) begin
        check(sv && sidx == 2'(j - 1), "R6 order", int'(sidx), j - 1);
        check(sig == 8'(sig_ref(exp_idx[j-1])), "R5 sigmoid", int'(sig), sig_ref(exp_idx[j-1]));
      end
      if (late_drop && j == 1) begin vld = 1'b1; smp = 8'(x - 55); end  // R9
      if (late_drop && j == 2) vld = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    check(!sv, "R8 valid low", int'(sv), 0);
    check(bus == 8'd0, "R8 bus idle", int'(bus), 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lfsr = 16'hACE1;
    for (int m = 0; m < T; m++) hist[m] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!sv, "R1 reset valid", int'(sv), 0);
    check(bus == 8'd0, "R1 reset bus", int'(bus), 0);
    rst_n = 1'b1;
    // R2 bias only, zero history
    run_sample(0, 0, 0);
    // R3 impulse walks through every tap
    run_sample(1, 0, 0);
    for (int k = 0; k < T; k++) run_sample(0, 0, 0);
    run_sample(40, 0, 0);
    for (int k = 0; k < T; k++) run_sample(0, 0, 0);
    // R4 saturation both ways
    for (int k = 0; k < T; k++) run_sample(127, 0, 0);
    for (int k = 0; k < T; k++) run_sample(-128, 0, 0);
    // R9 drops during multiply and during bus phase
    run_sample(9, 1, 0);
    run_sample(-6, 0, 1);
    run_sample(3, 1, 1);
    // small-value sweep through the linear segments
    for (int v = -12; v <= 12; v += 3) run_sample(v, 0, 0);
    // pseudo-random stream
    for (int k = 0; k < 30; k++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      run_sample((lfsr & 255) - 128, k % 7 == 3, k % 5 == 1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule